// File: doc/BRIEF.md
# Push-Button Gear Selector

This block turns two push buttons, one for "up / forward" and one for "down / back", into a drive gear choice among four gears: stop, first forward gear, second forward gear and reverse. Each button is brought into the clock domain by a flip-flop chain. A rising edge of the synchronised level makes a one-cycle press event, so a button held for any length of time moves the selector by exactly one step. The operator has to let go and press again to take another step.

The clock only sets when the gear register updates. The next gear depends on the current gear and the two press events. The active-low reset asserts asynchronously and releases through a local synchroniser. The same reset clears the press history, so a button that is already held when reset ends does not count as a press. Three output flags name the selected forward or reverse gear, and all three are low in stop. Parameters set the synchroniser depth, the reset-release depth and the encoding of the gear register (binary or one-hot).

Top module: `gear_sel_top`

## Requirements
- R1: While rst_n is low the selector is in stop with all three gear flags low, and this takes effect without waiting for a clock edge.
- R2: In stop, a forward press selects forward gear 1 and a back press selects reverse.
- R3: In forward gear 1, a forward press selects forward gear 2 and a back press returns to stop.
- R4: In forward gear 2, a forward press leaves forward gear 2 selected and a back press returns to stop.
- R5: In reverse, a forward press returns to stop and a back press leaves reverse selected.
- R6: When no press occurs the selected gear does not change, however many cycles pass.
- R7: A button held high for many cycles causes exactly one step. A further step needs the button to go low and then high again.
- R8: If forward and back press events arise in the same cycle, the gear is unchanged.
- R9: Output flags, written as {gear_rev_o, gear_fwd2_o, gear_fwd1_o}, read 000 in stop, 001 in forward gear 1, 010 in forward gear 2 and 100 in reverse. At most one flag is high at any time.
- R10: A button that is held high while reset releases and stays high afterwards causes no step. Its next fresh press does cause a step.
- R11: A button rising between clock edges changes the flags right after the (SYNC_STAGES+1)-th following rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; times the gear update only |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| btn_fwd_i | input | 1 | Forward push button level, asynchronous |
| btn_back_i | input | 1 | Back push button level, asynchronous |
| gear_fwd1_o | output | 1 | High while forward gear 1 is selected |
| gear_fwd2_o | output | 1 | High while forward gear 2 is selected |
| gear_rev_o | output | 1 | High while reverse is selected |

## Verification
The bench uses a three-stage button synchroniser (SYNC_STAGES=3) rather than the default two, together with the one-hot gear register (ONEHOT_STATE=1). This checks that the press latency follows the parameter: the flags still show the old gear after three edges and the new gear after four. It also runs the generate branch that encodes the gear code from one-hot bits. The reset-release depth stays at two, which is enough to cover a button that is held across reset release.

// File: rtl/gear_sel_pkg.sv
package gear_sel_pkg;

   typedef enum logic [1:0] {
      GEAR_STOP = 2'd0,
      GEAR_FWD1 = 2'd1,
      GEAR_FWD2 = 2'd2,
      GEAR_REV  = 2'd3
   } gear_e;

   localparam int unsigned NUM_GEARS = 4;
   localparam int unsigned NUM_BTNS  = 2;
   localparam int unsigned BTN_FWD   = 0;
   localparam int unsigned BTN_BACK  = 1;

   typedef struct packed {
      logic back;
      logic fwd;
   } press_t;

   typedef struct packed {
      logic rev;
      logic fwd2;
      logic fwd1;
   } gear_flags_t;

endpackage

// File: rtl/gear_sel_rst_sync.sv
module gear_sel_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_sync_n
);

   if (STAGES < 2) begin : g_bad_depth
      $error("gear_sel_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
   end

   assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gear_sel_press_det.sv
module gear_sel_press_det #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] btn_i,
   output logic [WIDTH-1:0] press_o
);

   if (STAGES < 2) begin : g_bad_depth
      $error("gear_sel_press_det: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gear_sel_press_det: WIDTH must be at least 1");
   end

   localparam int unsigned LAST = STAGES - 1;

   for (genvar b = 0; b < WIDTH; b++) begin : g_btn
      logic [STAGES-1:0] sync_q;
      logic              prev_q;

      // The chain keeps sampling during reset, so it already holds the
      // button level when reset releases.
      always_ff @(posedge clk) begin
         sync_q <= {sync_q[LAST-1:0], btn_i[b]};
      end

      // The history is preset to "pressed": a level held across reset
      // release never looks like a fresh rising edge.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b1;
         end else begin
            prev_q <= sync_q[LAST];
         end
      end

      assign press_o[b] = sync_q[LAST] & ~prev_q;
   end

endmodule

// File: rtl/gear_sel_next.sv
module gear_sel_next
   import gear_sel_pkg::*;
(
   input  gear_e  cur_i,
   input  press_t press_i,
   output gear_e  nxt_i
);

   always_comb begin
      nxt_i = cur_i;
      if (press_i.fwd ^ press_i.back) begin
         unique case (cur_i)
            GEAR_STOP: nxt_i = press_i.fwd ? GEAR_FWD1 : GEAR_REV;
            GEAR_FWD1: nxt_i = press_i.fwd ? GEAR_FWD2 : GEAR_STOP;
            GEAR_FWD2: nxt_i = press_i.fwd ? GEAR_FWD2 : GEAR_STOP;
            GEAR_REV:  nxt_i = press_i.fwd ? GEAR_STOP : GEAR_REV;
            default:   nxt_i = GEAR_STOP;
         endcase
      end
   end

endmodule

// File: rtl/gear_sel_top.sv
module gear_sel_top
   import gear_sel_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned RST_STAGES   = 2,
   parameter bit          ONEHOT_STATE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_fwd_i,
   input  logic btn_back_i,
   output logic gear_fwd1_o,
   output logic gear_fwd2_o,
   output logic gear_rev_o
);

   localparam int unsigned CODE_W = $clog2(NUM_GEARS);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gear_sel_top: SYNC_STAGES must be at least 2");
   end
   if (RST_STAGES < 2) begin : g_bad_rst
      $error("gear_sel_top: RST_STAGES must be at least 2");
   end

   logic                rst_sync_n;
   logic [NUM_BTNS-1:0] btn_vec;
   logic [NUM_BTNS-1:0] press_vec;
   press_t              press;
   logic                fwd_ev;
   logic                back_ev;
   gear_e               gear_code;
   gear_e               gear_nxt;
   gear_flags_t         flags;

   gear_sel_rst_sync #(
      .STAGES (RST_STAGES)
   ) u_rst_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_sync_n (rst_sync_n)
   );

   assign btn_vec[BTN_FWD]  = btn_fwd_i;
   assign btn_vec[BTN_BACK] = btn_back_i;

   gear_sel_press_det #(
      .WIDTH  (NUM_BTNS),
      .STAGES (SYNC_STAGES)
   ) u_press (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .btn_i   (btn_vec),
      .press_o (press_vec)
   );

   assign fwd_ev     = press_vec[BTN_FWD];
   assign back_ev    = press_vec[BTN_BACK];
   assign press.fwd  = fwd_ev;
   assign press.back = back_ev;

   gear_sel_next u_next (
      .cur_i   (gear_code),
      .press_i (press),
      .nxt_i   (gear_nxt)
   );

   if (ONEHOT_STATE) begin : g_onehot
      logic [NUM_GEARS-1:0] oh_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            oh_q <= NUM_GEARS'(1) << GEAR_STOP;
         end else if (!rst_sync_n) begin
            oh_q <= NUM_GEARS'(1) << GEAR_STOP;
         end else begin
            oh_q <= NUM_GEARS'(1) << gear_nxt;
         end
      end

      always_comb begin
         gear_code = GEAR_STOP;
         for (int g = 0; g < NUM_GEARS; g++) begin
            if (oh_q[g]) gear_code = gear_e'(CODE_W'(g));
         end
      end

      assign flags.fwd1 = oh_q[GEAR_FWD1];
      assign flags.fwd2 = oh_q[GEAR_FWD2];
      assign flags.rev  = oh_q[GEAR_REV];
   end else begin : g_binary
      gear_e code_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q <= GEAR_STOP;
         end else if (!rst_sync_n) begin
            code_q <= GEAR_STOP;
         end else begin
            code_q <= gear_nxt;
         end
      end

      assign gear_code  = code_q;
      assign flags.fwd1 = (code_q == GEAR_FWD1);
      assign flags.fwd2 = (code_q == GEAR_FWD2);
      assign flags.rev  = (code_q == GEAR_REV);
   end

   assign gear_fwd1_o = flags.fwd1;
   assign gear_fwd2_o = flags.fwd2;
   assign gear_rev_o  = flags.rev;

endmodule

// File: rtl/gear_sel_chk.sv
module gear_sel_chk
   import gear_sel_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  rst_sync_n,
   input logic  fwd_ev,
   input logic  back_ev,
   input gear_e gear_code,
   input logic  gear_fwd1_o,
   input logic  gear_fwd2_o,
   input logic  gear_rev_o
);

   // R1: reset forces stop
   p_reset_stop_r1: assert property (@(posedge clk)
      !rst_n |-> {gear_rev_o, gear_fwd2_o, gear_fwd1_o} == 3'b000);

   // R9: flags never overlap
   p_flags_onehot0_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gear_rev_o, gear_fwd2_o, gear_fwd1_o}));

   // R6: the gear moves only after a press event
   p_move_needs_press_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !$stable(gear_code) |-> $past(fwd_ev | back_ev));

   // R7: press events last one cycle
   p_fwd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      fwd_ev |=> !fwd_ev);
   p_back_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      back_ev |=> !back_ev);

   // R8: simultaneous presses hold the gear
   p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      fwd_ev && back_ev |=> $stable(gear_code));

   // R2: forward from stop
   p_stop_fwd_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      gear_code == GEAR_STOP && fwd_ev && !back_ev |=> gear_fwd1_o);

   // R4: forward in gear 2 saturates
   p_fwd2_sat_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      gear_code == GEAR_FWD2 && fwd_ev && !back_ev |=> gear_fwd2_o);

   // R5: forward from reverse goes to stop
   p_rev_fwd_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      gear_code == GEAR_REV && fwd_ev && !back_ev |=>
         {gear_rev_o, gear_fwd2_o, gear_fwd1_o} == 3'b000);

endmodule

bind gear_sel_top gear_sel_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rst_sync_n  (rst_sync_n),
   .fwd_ev      (fwd_ev),
   .back_ev     (back_ev),
   .gear_code   (gear_code),
   .gear_fwd1_o (gear_fwd1_o),
   .gear_fwd2_o (gear_fwd2_o),
   .gear_rev_o  (gear_rev_o)
);

// File: tb/gear_sel_top_tb_top.sv
`timescale 1ns/1ps
module gear_sel_top_tb_top;

   localparam int SYNC = 3;
   localparam int LAT  = SYNC + 1;
   localparam int GAP  = LAT + 4;

   localparam logic [2:0] F_STOP = 3'b000;
   localparam logic [2:0] F_FWD1 = 3'b001;
   localparam logic [2:0] F_FWD2 = 3'b010;
   localparam logic [2:0] F_REV  = 3'b100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_fwd = 1'b0;
   logic btn_back = 1'b0;
   logic f1, f2, rv;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   gear_sel_top #(
      .SYNC_STAGES  (SYNC),
      .RST_STAGES   (2),
      .ONEHOT_STATE (1'b1)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .btn_fwd_i   (btn_fwd),
      .btn_back_i  (btn_back),
      .gear_fwd1_o (f1),
      .gear_fwd2_o (f2),
      .gear_rev_o  (rv)
   );

   task automatic chk(input logic [2:0] exp, input string tag);
      n_cmp++;
      if ({rv, f2, f1} !== exp) begin
         n_bad++;
         $display("FAIL %s: flags got %b expected %b", tag, {rv, f2, f1}, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input logic f, input logic b);
      @(negedge clk);
      btn_fwd  = f;
      btn_back = b;
      idle(GAP);
      btn_fwd  = 1'b0;
      btn_back = 1'b0;
      idle(GAP);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(F_STOP, "R1 async reset");
      idle(6);
      rst_n = 1'b1;
      idle(6);
      chk(F_STOP, "R1 after release");
   endtask

   task automatic t_stop_paths();
      do_reset();
      press(1, 0); chk(F_FWD1, "R2 stop fwd");
      do_reset();
      press(0, 1); chk(F_REV,  "R2 stop back");
   endtask

   task automatic t_fwd1_paths();
      do_reset();
      press(1, 0); press(1, 0); chk(F_FWD2, "R3 fwd1 fwd");
      do_reset();
      press(1, 0); press(0, 1); chk(F_STOP, "R3 fwd1 back");
   endtask

   task automatic t_fwd2_paths();
      do_reset();
      press(1, 0); press(1, 0); press(1, 0); chk(F_FWD2, "R4 fwd2 saturates");
      press(0, 1); chk(F_STOP, "R4 fwd2 back");
   endtask

   task automatic t_rev_paths();
      do_reset();
      press(0, 1); press(0, 1); chk(F_REV,  "R5 rev back stays");
      press(1, 0); chk(F_STOP, "R5 rev fwd");
   endtask

   task automatic t_idle();
      do_reset();
      idle(40); chk(F_STOP, "R6 idle stop");
      press(1, 0); idle(40); chk(F_FWD1, "R6 idle fwd1");
      press(0, 1); press(0, 1); idle(40); chk(F_REV, "R6 idle rev");
   endtask

   task automatic t_hold();
      do_reset();
      @(negedge clk); btn_fwd = 1'b1;
      idle(50); chk(F_FWD1, "R7 held one step");
      btn_fwd = 1'b0; idle(GAP); chk(F_FWD1, "R7 release no step");
      press(1, 0); chk(F_FWD2, "R7 re-press steps");
   endtask

   task automatic t_both();
      do_reset();
      press(1, 0);
      press(1, 1); chk(F_FWD1, "R8 both in fwd1");
      do_reset();
      press(1, 1); chk(F_STOP, "R8 both in stop");
   endtask

   task automatic t_reset_held();
      do_reset();
      press(1, 0); press(1, 0);
      @(negedge clk); btn_fwd = 1'b1;
      idle(GAP);
      rst_n = 1'b0;
      #1;
      chk(F_STOP, "R1 reset while held");
      idle(6);
      rst_n = 1'b1;
      idle(30); chk(F_STOP, "R10 held across release");
      btn_fwd = 1'b0; idle(GAP);
      press(1, 0); chk(F_FWD1, "R10 fresh press after");
   endtask

   task automatic t_latency();
      do_reset();
      @(negedge clk); btn_back = 1'b1;
      idle(SYNC); chk(F_STOP, "R11 before latency");
      idle(1);    chk(F_REV,  "R11 at latency");
      btn_back = 1'b0; idle(GAP);
   endtask

   task automatic t_codes();
      do_reset(); chk(F_STOP, "R9 stop code");
      press(1, 0); chk(F_FWD1, "R9 fwd1 code");
      press(1, 0); chk(F_FWD2, "R9 fwd2 code");
      do_reset(); press(0, 1); chk(F_REV, "R9 rev code");
   endtask

   initial begin
      idle(8);
      rst_n = 1'b1;
      idle(4);
      t_stop_paths();
      t_fwd1_paths();
      t_fwd2_paths();
      t_rev_paths();
      t_idle();
      t_hold();
      t_both();
      t_reset_held();
      t_latency();
      t_codes();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule